// File: doc/BRIEF.md
# UART Register Front End

This block sits between a simple 32-bit register bus and the byte streams of a UART. Received bytes enter on a valid/ready input stream and wait in a small circular receive queue until software reads them through the receive-data register. A write to the transmit-data register hands its low byte to a single holding stage, which presents it on a valid/ready output stream toward the transmitter. There is no transmit queue.

The front end also holds four plain configuration words: interrupt enable, transmit control, receive control and a baud divisor. It derives a read-only pending word on the fly from the watermark count fields in the two control words and from queue occupancy. A single level interrupt output is formed from the enable word and the receive queue state.

Back-pressure rules: `rx_ready` is high exactly while the queue has a free slot. A byte offered with `rx_valid` while `rx_ready` is low is discarded, so the receiver must not rely on the byte being held. On the transmit side, `tx_valid` and `tx_data` hold steady until a cycle with `tx_ready` high. A transmit write that arrives while the holding stage is still occupied and not being drained is discarded.

Top module: `uart_regif`

## Requirements
- R1: After reset, `bus_rdata` is 0, `bus_err` is 0, `irq` is 0, `tx_valid` is 0, `rx_ready` is 1, and the enable, transmit control, receive control, divisor and pending registers read 0.
- R2: The registers sit at these byte offsets: 0x00 transmit data, 0x04 receive data, 0x08 transmit control, 0x0C receive control, 0x10 interrupt enable, 0x14 pending, 0x18 divisor. Enable, both control words and the divisor read back the last full 32-bit value written to them. Read data appears on `bus_rdata` in the cycle after `bus_rd`, and `bus_rdata` is 0 in every other cycle.
- R3: A read of receive data while the queue holds bytes returns the oldest byte in bits [7:0], with zeros above, and removes that byte. Bytes leave in arrival order.
- R4: A read of receive data while the queue is empty returns 0x8000_0000 and leaves the queue unchanged.
- R5: The queue holds DEPTH bytes (default 8). A byte is accepted at a clock edge where `rx_valid` and `rx_ready` are both high. A byte offered while the queue is full is dropped, and the stored contents stay unchanged.
- R6: A push and a pop at the same edge both take effect, and the occupancy stays the same.
- R7: A transmit-data write with the holding stage free drives `tx_data` with the low 8 bits of the written word, and `tx_valid` is high from the next cycle. Both hold until an edge with `tx_ready` high. A read of transmit data returns 0.
- R8: A transmit-data write while `tx_valid` is high and `tx_ready` is low is discarded. A write at an edge where the held byte is being taken loads the new byte.
- R9: Pending bit 0 is 1 when the count field at bits [18:16] of transmit control is nonzero. Pending bit 1 is 1 when the occupancy is strictly greater than the count field at bits [18:16] of receive control. All other pending bits are 0, and writes to the pending offset change nothing.
- R10: `irq` equals enable bit 0 OR (enable bit 1 AND queue not empty), evaluated from the current register state.
- R11: A read or write at any offset that is not one of the seven word-aligned offsets of R2 returns 0, has no effect, and raises `bus_err` for one cycle, aligned with the read data slot. Accesses at defined offsets leave `bus_err` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 5 | Byte offset of the access |
| bus_rd | input | 1 | Read strobe, one access per cycle |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the strobe |
| bus_err | output | 1 | Undefined-offset flag, aligned with read data slot |
| rx_valid | input | 1 | Received byte offered |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Queue has a free slot |
| tx_valid | output | 1 | Transmit byte held |
| tx_data | output | 8 | Transmit byte |
| tx_ready | input | 1 | Transmitter takes the held byte |
| irq | output | 1 | Level interrupt |

## Verification
The hardest conditions to reach are the queue edges where two things happen at once. These are a push and a pop at the same edge, a byte offered exactly when the queue is full, and a transmit write at the edge where the held byte is taken. The bench drives the receive stream and the bus strobe in the same cycle and fills the queue past its depth. It then sweeps every occupancy from empty to full against every receive count value and reads the pending word each time. This makes the strict-greater comparison and the drop-when-full rule visible at the ports.

// File: rtl/uart_regif_pkg.sv
package uart_regif_pkg;

  localparam int unsigned ADDR_W = 5;
  localparam int unsigned DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFF_TXDATA = 5'h00;
  localparam logic [ADDR_W-1:0] OFF_RXDATA = 5'h04;
  localparam logic [ADDR_W-1:0] OFF_TXCTL  = 5'h08;
  localparam logic [ADDR_W-1:0] OFF_RXCTL  = 5'h0C;
  localparam logic [ADDR_W-1:0] OFF_IEN    = 5'h10;
  localparam logic [ADDR_W-1:0] OFF_PEND   = 5'h14;
  localparam logic [ADDR_W-1:0] OFF_DIV    = 5'h18;

  localparam int unsigned IRQ_TX_BIT = 0;
  localparam int unsigned IRQ_RX_BIT = 1;

  localparam logic [DATA_W-1:0] RX_EMPTY_WORD = 32'h8000_0000;

  typedef enum logic [2:0] {
    SEL_TXDATA,
    SEL_RXDATA,
    SEL_TXCTL,
    SEL_RXCTL,
    SEL_IEN,
    SEL_PEND,
    SEL_DIV,
    SEL_NONE
  } reg_sel_e;

  function automatic reg_sel_e decode_off(input logic [ADDR_W-1:0] a);
    reg_sel_e s;
    case (a)
      OFF_TXDATA: s = SEL_TXDATA;
      OFF_RXDATA: s = SEL_RXDATA;
      OFF_TXCTL:  s = SEL_TXCTL;
      OFF_RXCTL:  s = SEL_RXCTL;
      OFF_IEN:    s = SEL_IEN;
      OFF_PEND:   s = SEL_PEND;
      OFF_DIV:    s = SEL_DIV;
      default:    s = SEL_NONE;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/uart_regif_rxq.sv
module uart_regif_rxq #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned DW    = 8,
  localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);

  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
  localparam logic [CW-1:0] CAP  = CW'(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wptr, rptr;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == LAST) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push) wptr <= bump(wptr);
      if (pop)  rptr <= bump(rptr);
      case ({push, pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  assign head  = mem[rptr];
  assign full  = (count == CAP);
  assign empty = (count == '0);

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  p_no_underflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
  p_count_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CAP);
  p_pushpop_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop) |=> $stable(count));

endmodule

// File: rtl/uart_regif_txhold.sv
module uart_regif_txhold #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_data,
  output logic          tx_valid,
  output logic [DW-1:0] tx_data,
  input  logic          tx_ready
);

  logic free;
  assign free = !tx_valid || tx_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_valid <= 1'b0;
      tx_data  <= '0;
    end else if (load && free) begin
      tx_valid <= 1'b1;
      tx_data  <= load_data;
    end else if (tx_valid && tx_ready) begin
      tx_valid <= 1'b0;
    end
  end

  p_hold_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
  p_load_shows_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !tx_valid) |=> (tx_valid && tx_data == $past(load_data)));

endmodule

// File: rtl/uart_regif_csr.sv
module uart_regif_csr
  import uart_regif_pkg::*;
#(
  parameter int unsigned CW      = 4,
  parameter int unsigned CNT_LSB = 16,
  parameter int unsigned CNT_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_err,
  input  logic [7:0]        q_head,
  input  logic [CW-1:0]     q_count,
  input  logic              q_empty,
  output logic              q_pop,
  output logic              tx_load,
  output logic [7:0]        tx_byte,
  output logic [1:0]        irq_en
);

  reg_sel_e          sel;
  logic [DATA_W-1:0] ien_q, txctl_q, rxctl_q, div_q;
  logic [DATA_W-1:0] pend, rd_mux;
  logic              wm_tx, wm_rx;

  assign sel = decode_off(bus_addr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ien_q   <= '0;
      txctl_q <= '0;
      rxctl_q <= '0;
      div_q   <= '0;
    end else if (bus_wr) begin
      case (sel)
        SEL_IEN:   ien_q   <= bus_wdata;
        SEL_TXCTL: txctl_q <= bus_wdata;
        SEL_RXCTL: rxctl_q <= bus_wdata;
        SEL_DIV:   div_q   <= bus_wdata;
        default:   ;
      endcase
    end
  end

  assign wm_tx = |txctl_q[CNT_LSB +: CNT_W];
  assign wm_rx = 32'(q_count) > 32'(rxctl_q[CNT_LSB +: CNT_W]);

  always_comb begin
    pend = '0;
    pend[IRQ_TX_BIT] = wm_tx;
    pend[IRQ_RX_BIT] = wm_rx;
  end

  always_comb begin
    case (sel)
      SEL_RXDATA: rd_mux = q_empty ? RX_EMPTY_WORD : {24'h0, q_head};
      SEL_TXCTL:  rd_mux = txctl_q;
      SEL_RXCTL:  rd_mux = rxctl_q;
      SEL_IEN:    rd_mux = ien_q;
      SEL_PEND:   rd_mux = pend;
      SEL_DIV:    rd_mux = div_q;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata <= '0;
      bus_err   <= 1'b0;
    end else begin
      bus_rdata <= bus_rd ? rd_mux : '0;
      bus_err   <= (bus_rd || bus_wr) && (sel == SEL_NONE);
    end
  end

  assign q_pop   = bus_rd && (sel == SEL_RXDATA) && !q_empty;
  assign tx_load = bus_wr && (sel == SEL_TXDATA);
  assign tx_byte = bus_wdata[7:0];
  assign irq_en  = {ien_q[IRQ_RX_BIT], ien_q[IRQ_TX_BIT]};

  p_err_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> ($past(bus_rd || bus_wr) && bus_rdata == '0));
  p_idle_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> bus_rdata == '0);

endmodule

// File: rtl/uart_regif.sv
module uart_regif
  import uart_regif_pkg::*;
#(
  parameter int unsigned DEPTH   = 8,
  parameter int unsigned CNT_LSB = 16,
  parameter int unsigned CNT_W   = 3,
  localparam int unsigned CW     = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_err,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  output logic              rx_ready,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  input  logic              tx_ready,
  output logic              irq
);

  logic [7:0]    q_head;
  logic [CW-1:0] q_count;
  logic          q_full, q_empty, q_pop, q_push;
  logic          tx_load;
  logic [7:0]    tx_byte;
  logic [1:0]    irq_en;

  assign rx_ready = !q_full;
  assign q_push   = rx_valid && rx_ready;

  uart_regif_rxq #(.DEPTH(DEPTH), .DW(8)) u_rxq (
    .clk(clk), .rst_n(rst_n),
    .push(q_push), .push_data(rx_data), .pop(q_pop),
    .head(q_head), .count(q_count), .full(q_full), .empty(q_empty)
  );

  uart_regif_csr #(.CW(CW), .CNT_LSB(CNT_LSB), .CNT_W(CNT_W)) u_csr (
    .clk(clk), .rst_n(rst_n),
    .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
    .q_head(q_head), .q_count(q_count), .q_empty(q_empty), .q_pop(q_pop),
    .tx_load(tx_load), .tx_byte(tx_byte), .irq_en(irq_en)
  );

  uart_regif_txhold #(.DW(8)) u_tx (
    .clk(clk), .rst_n(rst_n),
    .load(tx_load), .load_data(tx_byte),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready)
  );

  assign irq = irq_en[0] | (irq_en[1] & !q_empty);

  p_empty_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == OFF_RXDATA && q_empty) |=> bus_rdata == RX_EMPTY_WORD);
  p_full_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (q_full && rx_valid && !q_pop) |=> q_full);
  p_irq_rx_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en[1] && q_push) |=> irq);

endmodule

// File: tb/uart_regif_tb.sv
module uart_regif_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_err;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_ready;
  logic        tx_valid;
  logic [7:0]  tx_data;
  logic        tx_ready = 1'b0;
  logic        irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  byte unsigned mq[$];
  logic [31:0] txc_cur = '0, rxc_cur = '0;

  always #2 clk = ~clk;

  uart_regif u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_err(bus_err), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_ready(rx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d, output logic e);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata; e = bus_err;
  endtask

  task automatic push(input byte unsigned b);
    @(negedge clk);
    if (rx_ready) mq.push_back(b);
    rx_valid = 1'b1; rx_data = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  function automatic logic [31:0] exp_pend(input logic [31:0] tc, input logic [31:0] rc, input int occ);
    logic [31:0] v = '0;
    v[0] = (tc[18:16] != 3'd0);
    v[1] = (occ > int'(rc[18:16]));
    return v;
  endfunction

  initial begin : wdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] d;
    logic e;
    logic [4:0] regs[4];
    logic [31:0] pats[4];
    regs[0] = 5'h08; regs[1] = 5'h0C; regs[2] = 5'h10; regs[3] = 5'h18;
    pats[0] = 32'hFFFF_FFFF; pats[1] = 32'hA5A5_5A5A; pats[2] = 32'h0001_0000; pats[3] = 32'h1234_5678;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 rdata", bus_rdata, 0);
    chk("R1 err", {31'b0, bus_err}, 0);
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 tx_valid", {31'b0, tx_valid}, 0);
    chk("R1 rx_ready", {31'b0, rx_ready}, 1);
    for (int i = 0; i < 4; i++) begin
      rd(regs[i], d, e); chk("R1 reg zero", d, 0);
    end
    rd(5'h14, d, e); chk("R1 pend zero", d, 0);

    // R2 readback sweep
    for (int p = 0; p < 4; p++)
      for (int i = 0; i < 4; i++) begin
        wr(regs[i], pats[p] ^ (32'h1 << i));
        rd(regs[i], d, e);
        chk("R2 readback", d, pats[p] ^ (32'h1 << i));
        chk("R2 no err", {31'b0, e}, 0);
      end
    wr(5'h08, 0); wr(5'h0C, 0); wr(5'h10, 0); wr(5'h18, 32'hCAFE_0001);

    // R11 undefined offsets
    for (int a = 0; a < 32; a++) begin
      if (a % 4 != 0 || a > 24) begin
        wr(5'(a), 32'hFFFF_FFFF);
        chk("R11 wr err", {31'b0, bus_err}, 1);
        rd(5'(a), d, e);
        chk("R11 rd zero", d, 0);
        chk("R11 rd err", {31'b0, e}, 1);
      end
    end
    rd(5'h18, d, e); chk("R11 div untouched", d, 32'hCAFE_0001);
    rd(5'h10, d, e); chk("R11 ien untouched", d, 0);
    @(negedge clk); chk("R11 err one cycle", {31'b0, bus_err}, 0);

    // R4 empty read
    rd(5'h04, d, e); chk("R4 empty word", d, 32'h8000_0000);
    rd(5'h04, d, e); chk("R4 still empty", d, 32'h8000_0000);

    // R9 tx watermark sweep, pend writes ignored
    for (int c = 0; c < 8; c++) begin
      txc_cur = 32'(c) << 16;
      wr(5'h08, txc_cur);
      rd(5'h14, d, e); chk("R9 tx wm", d, exp_pend(txc_cur, rxc_cur, 0));
    end
    txc_cur = 0; wr(5'h08, 0);
    wr(5'h14, 32'hFFFF_FFFF);
    rd(5'h14, d, e); chk("R9 pend write ignored", d, 0);

    // R10 irq with empty queue
    for (int ie = 0; ie < 4; ie++) begin
      wr(5'h10, 32'(ie));
      chk("R10 irq empty", {31'b0, irq}, {31'b0, ie[0]});
    end

    // R5/R9 fill with occupancy x rx count sweep
    for (int k = 0; k <= 8; k++) begin
      if (k > 0) push(8'(8'h30 + k));
      chk("R5 rx_ready", {31'b0, rx_ready}, {31'b0, (k < 8)});
      for (int c = 0; c < 8; c++) begin
        rxc_cur = (32'(c) << 16) | 32'hF000_0000;
        wr(5'h0C, rxc_cur);
        rd(5'h14, d, e); chk("R9 rx wm", d, exp_pend(txc_cur, rxc_cur, mq.size()));
      end
    end
    for (int ie = 0; ie < 4; ie++) begin
      wr(5'h10, 32'(ie));
      chk("R10 irq nonempty", {31'b0, irq}, {31'b0, ie[0] | ie[1]});
    end
    wr(5'h10, 0);
    // R5 drop while full
    push(8'hEE); push(8'hEF);
    chk("R5 model size", 32'(mq.size()), 8);
    // R3 drain in order
    while (mq.size() > 0) begin
      rd(5'h04, d, e);
      chk("R3 oldest byte", d, {24'h0, mq.pop_front()});
    end
    chk("R5 ready after drain", {31'b0, rx_ready}, 1);
    rd(5'h04, d, e); chk("R4 after drain", d, 32'h8000_0000);

    // R6 simultaneous push and pop
    push(8'h11); push(8'h22); push(8'h33);
    @(negedge clk);
    bus_addr = 5'h04; bus_rd = 1'b1; rx_valid = 1'b1; rx_data = 8'h44;
    mq.push_back(8'h44);
    @(negedge clk);
    bus_rd = 1'b0; rx_valid = 1'b0;
    chk("R6 pop data", bus_rdata, {24'h0, mq.pop_front()});
    rxc_cur = 32'h2 << 16; wr(5'h0C, rxc_cur);
    rd(5'h14, d, e); chk("R6 count above 2", d, 32'h2);
    rxc_cur = 32'h3 << 16; wr(5'h0C, rxc_cur);
    rd(5'h14, d, e); chk("R6 count not above 3", d, 32'h0);
    while (mq.size() > 0) begin
      rd(5'h04, d, e);
      chk("R6 order", d, {24'h0, mq.pop_front()});
    end

    // R7 transmit path
    tx_ready = 1'b0;
    wr(5'h00, 32'h0000_01A5);
    chk("R7 tx_valid", {31'b0, tx_valid}, 1);
    chk("R7 tx_data", {24'h0, tx_data}, 32'hA5);
    rd(5'h00, d, e); chk("R7 txdata reads zero", d, 0);
    // R8 write while busy discarded
    wr(5'h00, 32'h0000_005C);
    chk("R8 busy discard", {24'h0, tx_data}, 32'hA5);
    repeat (3) @(negedge clk);
    chk("R7 held", {23'h0, tx_valid, tx_data}, 32'h1A5);
    // R8 write at take edge loads new byte
    @(negedge clk);
    tx_ready = 1'b1; bus_addr = 5'h00; bus_wdata = 32'h77; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    chk("R8 reload", {23'h0, tx_valid, tx_data}, 32'h177);
    @(negedge clk);
    chk("R7 drained", {31'b0, tx_valid}, 0);
    for (int b = 0; b < 256; b += 37) begin
      wr(5'h00, 32'hFFFF_FF00 | 32'(b));
      chk("R7 byte sweep", {23'h0, tx_valid, tx_data}, 32'h100 | 32'(b));
    end
    tx_ready = 1'b0;

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule